// File: doc/BRIEF.md
# Prescaled Dual 8-bit Timer Pair

The block holds two 8-bit up-counters. Both take their count enables from one shared 9-bit prescaler. The prescaler takes its input from one of three sources:

- a slow-clock tick;
- the system clock slowed by a gear ratio of 2^g;
- the system clock divided by 16.

A fixed divide-by-4 stage sits between the chosen source and the prescaler. The prescaler provides four taps, each one a single-cycle enable. Their periods are 8, 32, 128 and 2048 source-clock cycles.

Each counter picks its enable from its own list of sources. The lower counter can also count rising edges on an external pin. The upper counter can count the lower counter's compare matches, or it can be chained to the lower counter as the top byte of a 16-bit counter.

All logic runs on the single system clock, and every count step is a clock enable. In 8-bit mode each counter clears itself on a compare match. In 16-bit mode the two compare bytes form one 16-bit compare value, and a match clears the whole pair.

Top module: `prescaled_timer_pair`

## Requirements
- R1: While `rst_ni` is low, both counts are zero and all match and overflow outputs are low.
- R2: With gear 0 and source code 00, taps 0, 1, 2 and 3 fire every 8, 32, 128 and 2048 system-clock cycles.
- R3: A gear value g multiplies every tap period by 2^g, and gear values above 4 act as 4. Source codes with bit 1 set (10, 11) use the system clock divided by 16 instead of the geared clock, so tap 0 then has a period of 128 cycles.
- R4: With `slow_sel_i` high, the prescaler source is `fs_tick_i`, and one source cycle is one high cycle of that input.
- R5: While `pre_run_i` is low, the prescaler and its dividers sit at zero and no tap fires. The first count through tap 0 (gear 0) comes 8 clock edges after `pre_run_i` rises.
- R6: `clk0_sel_i` picks the lower counter's enable: 00 selects external pin rising edges, 01 tap 0, 10 tap 1 and 11 tap 2.
- R7: Each rising edge on `ext_pin_i` advances the lower counter exactly once. The pin passes through two synchronizer stages, so the count changes 3 clocks after the pin is first sampled high.
- R8: While a counter's run bit is low, that counter reads zero and does not count.
- R9: In 8-bit mode, a count enable that arrives while a counter equals its compare value clears the counter to zero and pulses its match output for one cycle. The counter never passes its compare value, so the match period is compare+1 enables.
- R10: In 8-bit mode, `clk1_sel_i` picks the upper counter's enable: 00 selects the lower counter's match, 01 tap 0, 10 tap 2 and 11 tap 3.
- R11: With `mode16_i` high, the upper counter advances on the same edge at which the lower counter steps from 0xFF to 0x00.
- R12: With `mode16_i` high, a lower count enable that arrives while {cnt1, cnt0} equals {cmp1, cmp0} clears both counters and pulses `match1_o`. `match0_o` stays low in this mode.
- R13: A counter that steps from 0xFF to 0x00, whether by incrementing or by a match at 0xFF, pulses its overflow output for one cycle on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_tick_i | input | 1 | Slow-clock tick, one cycle wide |
| slow_sel_i | input | 1 | Use the slow clock as the prescaler source |
| gear_i | input | 3 | Gear exponent g, giving fc/2^g |
| psrc_sel_i | input | 2 | Prescaler source: 00 geared clock, 10 fc/16 |
| pre_run_i | input | 1 | Prescaler run; low clears the prescaler |
| run0_i | input | 1 | Lower counter run |
| run1_i | input | 1 | Upper counter run |
| clk0_sel_i | input | 2 | Lower counter enable select |
| clk1_sel_i | input | 2 | Upper counter enable select (8-bit mode) |
| mode16_i | input | 1 | Chain both counters as one 16-bit counter |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| cmp0_i | input | 8 | Lower compare value |
| cmp1_i | input | 8 | Upper compare value |
| cnt0_o | output | 8 | Lower count |
| cnt1_o | output | 8 | Upper count |
| match0_o | output | 1 | Lower match pulse |
| match1_o | output | 1 | Upper (or 16-bit) match pulse |
| ovf0_o | output | 1 | Lower overflow pulse |
| ovf1_o | output | 1 | Upper overflow pulse |

## Verification
Counts, match pulses and overflow pulses all change on the clock edge that carries the count enable. The bench therefore compares them together, in the same falling-edge sample. Tap periods are measured as the number of edges between two consecutive count changes, so the unknown phase of the first step does not enter the result. Pin edges take 3 edges to reach the count, and the restart latency of the prescaler is 8 edges. The bench waits at least that many cycles before it reads these results, and it compares each reading against the next item in its expected-value queue.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned PRE_W  = 9;
  localparam int unsigned GEAR_W = 3;
  localparam int unsigned GDIV_W = 4;
  localparam int unsigned NTAP   = 4;

  typedef enum logic [1:0] {
    LO_EXT = 2'b00,
    LO_T1  = 2'b01,
    LO_T4  = 2'b10,
    LO_T16 = 2'b11
  } lo_sel_e;

  typedef enum logic [1:0] {
    HI_MATCH = 2'b00,
    HI_T1    = 2'b01,
    HI_T16   = 2'b10,
    HI_T256  = 2'b11
  } hi_sel_e;

  // prescaler bit count below each tap's carry (periods in base ticks: 2,8,32,512)
  function automatic int unsigned tap_pos(int unsigned i);
    case (i)
      0: return 1;
      1: return 3;
      2: return 5;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned P_W = PRE_W,
  parameter int unsigned G_W = GEAR_W,
  parameter int unsigned D_W = GDIV_W,
  parameter int unsigned T_N = NTAP
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           slow_sel_i,
  input  logic           fs_tick_i,
  input  logic [G_W-1:0] gear_i,
  input  logic [1:0]     src_sel_i,
  output logic [T_N-1:0] tap_o
);
  logic [D_W-1:0] gdiv_q, gmask;
  logic [1:0]     div4_q;
  logic [P_W-1:0] pre_q;
  logic           gear_en, fc16_en, src_en, base_en;

  always_comb begin
    for (int i = 0; i < int'(D_W); i++) gmask[i] = (32'(gear_i) > i);
  end

  assign gear_en = ((gdiv_q & gmask) == gmask);
  assign fc16_en = &gdiv_q;
  assign src_en  = slow_sel_i ? fs_tick_i : (src_sel_i[1] ? fc16_en : gear_en);
  assign base_en = src_en && (div4_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gdiv_q <= '0;
      div4_q <= '0;
      pre_q  <= '0;
    end else if (!run_i) begin
      gdiv_q <= '0;
      div4_q <= '0;
      pre_q  <= '0;
    end else begin
      gdiv_q <= gdiv_q + 1'b1;
      if (src_en)  div4_q <= div4_q + 1'b1;
      if (base_en) pre_q  <= pre_q + 1'b1;
    end
  end

  for (genvar t = 0; t < int'(T_N); t++) begin : g_tap
    localparam int unsigned P = tap_pos(t);
    assign tap_o[t] = base_en && (&pre_q[P-1:0]);
  end

  p_stop_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0));
  p_tap_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[0] |=> !tap_o[0]);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_rise_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_q;
  logic         wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= inc_i && (cnt_q == TOP);
      if (clr_i)      cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  p_run_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0));
  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && inc_i && !clr_i |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !inc_i && !clr_i |=> $stable(cnt_o));
endmodule

// File: rtl/prescaled_timer_pair.sv
module prescaled_timer_pair
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_tick_i,
  input  logic              slow_sel_i,
  input  logic [GEAR_W-1:0] gear_i,
  input  logic [1:0]        psrc_sel_i,
  input  logic              pre_run_i,
  input  logic              run0_i,
  input  logic              run1_i,
  input  logic [1:0]        clk0_sel_i,
  input  logic [1:0]        clk1_sel_i,
  input  logic              mode16_i,
  input  logic              ext_pin_i,
  input  logic [CNT_W-1:0]  cmp0_i,
  input  logic [CNT_W-1:0]  cmp1_i,
  output logic [CNT_W-1:0]  cnt0_o,
  output logic [CNT_W-1:0]  cnt1_o,
  output logic              match0_o,
  output logic              match1_o,
  output logic              ovf0_o,
  output logic              ovf1_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [NTAP-1:0] tap;
  logic ext_rise, lo_src, hi_src, en0, en1, wide_hit, lo_top, hit_lo, hit_hi;
  logic match0_q, match1_q;

  tmr_prescaler #(.P_W(PRE_W), .G_W(GEAR_W), .D_W(GDIV_W), .T_N(NTAP)) u_pre (
    .clk_i, .rst_ni, .run_i(pre_run_i), .slow_sel_i, .fs_tick_i,
    .gear_i, .src_sel_i(psrc_sel_i), .tap_o(tap)
  );

  tmr_edge_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .rise_o(ext_rise)
  );

  always_comb begin
    case (lo_sel_e'(clk0_sel_i))
      LO_EXT:  lo_src = ext_rise;
      LO_T1:   lo_src = tap[0];
      LO_T4:   lo_src = tap[1];
      default: lo_src = tap[2];
    endcase
    en0      = run0_i & lo_src;
    wide_hit = ({cnt1_o, cnt0_o} == {cmp1_i, cmp0_i});
    lo_top   = (cnt0_o == TOP);
    hit_lo   = en0 & (mode16_i ? wide_hit : (cnt0_o == cmp0_i));
    case (hi_sel_e'(clk1_sel_i))
      HI_MATCH: hi_src = hit_lo;
      HI_T1:    hi_src = tap[0];
      HI_T16:   hi_src = tap[2];
      default:  hi_src = tap[3];
    endcase
    en1    = run1_i & (mode16_i ? (en0 & lo_top) : hi_src);
    hit_hi = mode16_i ? hit_lo : (en1 & (cnt1_o == cmp1_i));
  end

  tmr_counter #(.W(CNT_W)) u_lo (
    .clk_i, .rst_ni, .run_i(run0_i), .inc_i(en0), .clr_i(hit_lo),
    .cnt_o(cnt0_o), .wrap_o(ovf0_o)
  );

  tmr_counter #(.W(CNT_W)) u_hi (
    .clk_i, .rst_ni, .run_i(run1_i), .inc_i(en1), .clr_i(hit_hi),
    .cnt_o(cnt1_o), .wrap_o(ovf1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match0_q <= 1'b0;
      match1_q <= 1'b0;
    end else begin
      match0_q <= hit_lo & ~mode16_i;
      match1_q <= hit_hi;
    end
  end

  assign match0_o = match0_q;
  assign match1_o = match1_q;

  p_cnt_le_cmp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode16_i && run0_i && (cnt0_o <= cmp0_i) |=> (cnt0_o <= $past(cmp0_i)));
  p_match_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match0_o |=> !match0_o);
  p_wide_carry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode16_i && run1_i && en0 && lo_top && !wide_hit |=> (cnt1_o == $past(cnt1_o) + 1'b1));
  p_m0_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode16_i |=> !match0_o);
  p_wide_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode16_i && hit_lo |=> (cnt0_o == '0) && (cnt1_o == '0));
endmodule

// File: tb/prescaled_timer_pair_tb_top.sv
module prescaled_timer_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fs_tick, slow_sel, pre_run, run0, run1, mode16, ext_pin;
  logic [2:0] gear;
  logic [1:0] psrc, sel0, sel1;
  logic [7:0] cmp0, cmp1, cnt0, cnt1;
  logic       m0, m1, o0, o1;

  int n_chk = 0;
  int n_bad = 0;
  int fs_div = 0;
  int m0_seen = 0;

  typedef struct {
    string req;
    int    val;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  prescaled_timer_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fs_tick_i(fs_tick), .slow_sel_i(slow_sel),
    .gear_i(gear), .psrc_sel_i(psrc), .pre_run_i(pre_run), .run0_i(run0),
    .run1_i(run1), .clk0_sel_i(sel0), .clk1_sel_i(sel1), .mode16_i(mode16),
    .ext_pin_i(ext_pin), .cmp0_i(cmp0), .cmp1_i(cmp1), .cnt0_o(cnt0),
    .cnt1_o(cnt1), .match0_o(m0), .match1_o(m1), .ovf0_o(o0), .ovf1_o(o1)
  );

  always @(negedge clk) begin
    fs_div  <= (fs_div == 4) ? 0 : fs_div + 1;
    fs_tick <= (fs_div == 4);
    if (m0) m0_seen <= m0_seen + 1;
  end

  task automatic push_exp(string r, int v);
    exp_q.push_back('{r, v});
  endtask

  task automatic mon_cmp(int act);
    exp_t e;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard empty act=%0d exp=none", act);
      return;
    end
    e = exp_q.pop_front();
    n_chk++;
    if (act != e.val) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", e.req, act, e.val);
    end
  endtask

  task automatic gap(input bit upper, output int n);
    logic [7:0] p;
    int k;
    p = upper ? cnt1 : cnt0;
    k = 0;
    while (((upper ? cnt1 : cnt0) == p) && k < 6000) begin @(negedge clk); k++; end
    p = upper ? cnt1 : cnt0;
    n = 0;
    while (((upper ? cnt1 : cnt0) == p) && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic setup(logic [1:0] s0, logic [1:0] s1, logic [7:0] c0, logic [7:0] c1, logic m);
    @(negedge clk);
    sel0 = s0; sel1 = s1; cmp0 = c0; cmp1 = c1; mode16 = m;
    run0 = 1'b0; run1 = 1'b0;
    @(negedge clk);
    run0 = 1'b1; run1 = 1'b1;
  endtask

  task automatic wait_until_lo(logic [7:0] v, bit eq);
    int k = 0;
    while (((cnt0 == v) != eq) && k < 6000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    rst_n = 1'b0; slow_sel = 0; gear = 0; psrc = 2'b00; pre_run = 1;
    run0 = 0; run1 = 0; mode16 = 0; ext_pin = 0; sel0 = 2'b01; sel1 = 2'b01;
    cmp0 = 8'hFF; cmp1 = 8'hFF;
    repeat (3) @(negedge clk);
    run0 = 1; run1 = 1;
    @(negedge clk);
    // R1: held in reset even with run bits high
    push_exp("R1 cnt0", 0); mon_cmp(cnt0);
    push_exp("R1 cnt1", 0); mon_cmp(cnt1);
    push_exp("R1 pulses", 0); mon_cmp(int'({m0, m1, o0, o1}));
    rst_n = 1'b1;

    // R2 / R6: lower taps at gear 0
    setup(2'b01, 2'b01, 8'hFF, 8'hFF, 0);
    push_exp("R2/R6 T1 gap", 8);    gap(0, g); mon_cmp(g);
    setup(2'b10, 2'b01, 8'hFF, 8'hFF, 0);
    push_exp("R2/R6 T4 gap", 32);   gap(0, g); mon_cmp(g);
    setup(2'b11, 2'b01, 8'hFF, 8'hFF, 0);
    push_exp("R2/R6 T16 gap", 128); gap(0, g); mon_cmp(g);

    // R10 / R2: upper taps
    setup(2'b01, 2'b01, 8'hFF, 8'hFF, 0);
    push_exp("R10 upper T1 gap", 8);      gap(1, g); mon_cmp(g);
    setup(2'b01, 2'b10, 8'hFF, 8'hFF, 0);
    push_exp("R10 upper T16 gap", 128);   gap(1, g); mon_cmp(g);
    setup(2'b01, 2'b11, 8'hFF, 8'hFF, 0);
    push_exp("R2/R10 upper T256 gap", 2048); gap(1, g); mon_cmp(g);

    // R3: gear and source code
    @(negedge clk); gear = 3'd2;
    setup(2'b01, 2'b01, 8'hFF, 8'hFF, 0);
    push_exp("R3 gear2 T1 gap", 32);  gap(0, g); mon_cmp(g);
    @(negedge clk); gear = 3'd6;
    push_exp("R3 gear6 T1 gap", 128); gap(0, g); mon_cmp(g);
    @(negedge clk); gear = 3'd0; psrc = 2'b10;
    push_exp("R3 fc16 T1 gap", 128);  gap(0, g); mon_cmp(g);
    @(negedge clk); psrc = 2'b00;

    // R4: slow clock source, tick every 5 cycles
    @(negedge clk); slow_sel = 1;
    gap(0, g);
    push_exp("R4 slow T1 gap", 40); gap(0, g); mon_cmp(g);
    @(negedge clk); slow_sel = 0;

    // R5: prescaler stop and restart latency
    setup(2'b01, 2'b01, 8'hFF, 8'hFF, 0);
    gap(0, g);
    @(negedge clk); pre_run = 0;
    begin
      logic [7:0] p;
      int n;
      p = cnt0;
      repeat (60) @(negedge clk);
      push_exp("R5 stopped count", int'(p)); mon_cmp(int'(cnt0));
      pre_run = 1;
      n = 0;
      while (cnt0 == p && n < 100) begin @(negedge clk); n++; end
      push_exp("R5 restart latency", 8); mon_cmp(n);
    end

    // R8: run bit clears and holds counter
    @(negedge clk); run0 = 0;
    @(negedge clk);
    push_exp("R8 cleared", 0); mon_cmp(int'(cnt0));
    repeat (40) @(negedge clk);
    push_exp("R8 held", 0); mon_cmp(int'(cnt0));
    run0 = 1;

    // R7 / R6: external pin edges
    setup(2'b00, 2'b01, 8'hFF, 8'hFF, 0);
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1; repeat (3) @(negedge clk);
      ext_pin = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    push_exp("R7/R6 pin edges", 5); mon_cmp(int'(cnt0));
    ext_pin = 1; @(negedge clk); @(negedge clk);
    push_exp("R7 latency before", 5); mon_cmp(int'(cnt0));
    @(negedge clk);
    push_exp("R7 latency at 3", 6); mon_cmp(int'(cnt0));
    ext_pin = 0;

    // R9: 8-bit match
    setup(2'b01, 2'b00, 8'd3, 8'hFF, 0);
    begin
      int mx = 0;
      int n;
      int k = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (int'(cnt0) > mx) mx = int'(cnt0);
      end
      push_exp("R9 max count", 3); mon_cmp(mx);
      while (!m0 && k < 200) begin @(negedge clk); k++; end
      push_exp("R9 count at match", 0); mon_cmp(int'(cnt0));
      @(negedge clk);
      push_exp("R9 pulse width", 0); mon_cmp(int'(m0));
      n = 1;
      while (!m0 && n < 200) begin @(negedge clk); n++; end
      push_exp("R9 match period", 32); mon_cmp(n);
    end
    // R10: upper counts lower matches
    push_exp("R10 upper on match gap", 32); gap(1, g); mon_cmp(g);

    // R13: 8-bit overflow with compare 0xFF
    setup(2'b01, 2'b01, 8'hFF, 8'hFF, 0);
    wait_until_lo(8'hFF, 1);
    wait_until_lo(8'hFF, 0);
    push_exp("R13 ovf0 on wrap", 1);  mon_cmp(int'(o0));
    push_exp("R13 match0 at FF", 1); mon_cmp(int'(m0));

    // R11 / R12 / R13: 16-bit mode, compare 0x0102
    setup(2'b01, 2'b01, 8'h02, 8'h01, 1);
    @(negedge clk); m0_seen = 0;
    begin
      int k = 0;
      while (cnt1 != 8'd1 && k < 6000) begin @(negedge clk); k++; end
      push_exp("R11 lower at carry", 0); mon_cmp(int'(cnt0));
      push_exp("R13 ovf0 at carry", 1);  mon_cmp(int'(o0));
      k = 0;
      while (!m1 && k < 6000) begin @(negedge clk); k++; end
      push_exp("R12 match1 seen", 1);   mon_cmp(int'(m1));
      push_exp("R12 cleared lo", 0);    mon_cmp(int'(cnt0));
      push_exp("R12 cleared hi", 0);    mon_cmp(int'(cnt1));
      push_exp("R12 match0 quiet", 0);  mon_cmp(m0_seen);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule